// File: doc/BRIEF.md
# Serial command word receiver

This block takes 16-bit command words from a synchronous serial port driven by a DSP or microcontroller. The port has four wires: an active-low select, a frame-sync strobe, a serial clock and a data line. All four arrive asynchronously. Each one passes through a synchroniser into the system clock domain, and edges are then detected on the synchronised levels. A frame opens when frame sync falls while the block is selected. Data bits are taken on each falling serial-clock edge, first bit first. Once all sixteen have arrived, the word is released on whichever comes first: the next rising edge of the serial clock or the next rising edge of frame sync.

The released word appears on a parallel output together with a one-cycle valid strobe, and it stays unchanged until the next strobe. The select may be driven per transfer, which lets several receivers share one port. It may also be tied low for a three-wire link. The serial clock must run slower than a quarter of the system clock. The block does not interpret the word.

Top module: `serial_cmd_rx`

## Requirements
- R1: While `sel_n_i` is high, the block ignores all activity on the other serial inputs: it issues no strobe and `word_o` keeps its value.
- R2: A falling edge of `fsync_i` while selected starts a new frame and clears the bit count, so bits taken before it are dropped from the next word.
- R3: Data is taken from `sdata_i` on falling edges of `sclk_i`. The first bit received lands in `word_o[15]` and the last in `word_o[0]`.
- R4: A word needs exactly sixteen captured bits. If a frame has only fifteen, a following rising edge of `sclk_i` or `fsync_i` produces no strobe.
- R5: After the sixteenth bit, a rising edge of `sclk_i` releases the word.
- R6: After the sixteenth bit, a rising edge of `fsync_i` that comes before any `sclk_i` rise releases the word.
- R7: With `sel_n_i` held low throughout (three-wire use), consecutive frames each deliver their word.
- R8: If `sel_n_i` rises before sixteen bits are captured, the partial word is discarded with no strobe, and the next frame is received correctly.
- R9: Serial clock activity after a word has been released and before the next frame start has no effect on the output.
- R10: `word_vld_o` is high for exactly one clock per word, and `word_o` changes only in the cycle where `word_vld_o` is high.
- R11: With the default two synchroniser stages, `word_vld_o` goes high after the third rising clock edge that samples the releasing pin edge. It stays low after the first two.
- R12: After reset, `word_o` is zero and `word_vld_o` is low.
- R13: If `sel_n_i` rises in the same system clock sample as the releasing edge, deselection wins: no strobe is issued and `word_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low select (tie low for three-wire use) |
| fsync_i | input | 1 | Frame sync; falling edge opens a frame |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data, first bit is the word's MSB |
| word_o | output | WORD_W | Last received word |
| word_vld_o | output | 1 | One-cycle strobe when `word_o` is updated |

## Verification
The release of a completed word and the deselection of the block can fall in the same system clock sample. When that happens, either the strobe or the discard must win. The bench provokes this by raising `sclk_i` and `sel_n_i` on the same clock after the sixteenth bit, so both pass through synchronisers of equal depth and reach the frame logic together. The bench judges the outcome against a behavioural model that gives deselection priority. It requires that no strobe appears and that `word_o` keeps the previous word.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;

    // Serial pins grouped so that synchroniser and edge logic treat them alike
    typedef struct packed {
        logic sel_n;
        logic fs;
        logic sck;
        logic dat;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // Idle levels: deselected, frame sync high, serial clock high, data low
    localparam pins_t PIN_IDLE = '{sel_n: 1'b1, fs: 1'b1, sck: 1'b1, dat: 1'b0};

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/serial_cmd_rx_sync.sv
module serial_cmd_rx_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    assign chain_d[0] = async_i;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            assign chain_d[g] = chain_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/serial_cmd_rx_edge.sv
module serial_cmd_rx_edge #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    assign prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/serial_cmd_rx_frame.sv
module serial_cmd_rx_frame
    import serial_cmd_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pins_t             lvl_i,
    input  pins_t             rise_i,
    input  pins_t             fall_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o
);

    localparam int                CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(WORD_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
        logic              vld;
    } regs_t;

    localparam regs_t REGS_RST = '{RX_IDLE, '0, '0, '0, 1'b0};

    regs_t r_d;
    regs_t r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (lvl_i.sel_n) begin
            // deselected: drop any frame in progress, including a full one
            r_d.state = RX_IDLE;
            r_d.cnt   = '0;
        end else if (fall_i.fs) begin
            r_d.state = RX_SHIFT;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                RX_SHIFT: begin
                    if (fall_i.sck) begin
                        r_d.shreg = {r_q.shreg[WORD_W-2:0], lvl_i.dat};
                        if (r_q.cnt == LAST) begin
                            r_d.state = RX_FULL;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                RX_FULL: begin
                    if (rise_i.sck || rise_i.fs) begin
                        r_d.word  = r_q.shreg;
                        r_d.vld   = 1'b1;
                        r_d.state = RX_IDLE;
                    end
                end
                default: begin
                    r_d.state = RX_IDLE;
                    r_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o = r_q.word;
    assign vld_o  = r_q.vld;

    // R10: strobe lasts a single cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

    // R10: word moves only together with the strobe
    a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> $stable(word_o));

    // R4: entering the full state needs a serial clock fall in the cycle before
    a_r4_full_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == RX_FULL) |-> $past(fall_i.sck));

    // R4: the bit count is cleared whenever no frame is open
    a_r4_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_IDLE) |-> (r_q.cnt == '0));

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import serial_cmd_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              fsync_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);

    pins_t raw_pins;
    pins_t lvl_pins;
    pins_t rise_pins;
    pins_t fall_pins;

    assign raw_pins = '{sel_n: sel_n_i, fs: fsync_i, sck: sclk_i, dat: sdata_i};

    serial_cmd_rx_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pins),
        .sync_o  (lvl_pins)
    );

    serial_cmd_rx_edge #(
        .W       (PIN_W),
        .RST_VAL (PIN_IDLE)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_pins),
        .rise_o  (rise_pins),
        .fall_o  (fall_pins)
    );

    serial_cmd_rx_frame #(
        .WORD_W (WORD_W)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_pins),
        .rise_i (rise_pins),
        .fall_i (fall_pins),
        .word_o (word_o),
        .vld_o  (word_vld_o)
    );

    // R1: a synchronised deselect blocks the strobe on the next edge
    a_r1_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_pins.sel_n |=> !word_vld_o);

    // R5: every strobe follows a detected serial clock or frame sync rise
    a_r5_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(rise_pins.sck || rise_pins.fs));

endmodule

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        fs = 1'b1;
    logic        sck = 1'b1;
    logic        dat = 1'b0;
    logic [15:0] word;
    logic        vld;

    int    checks = 0;
    int    errors = 0;
    int    strobes = 0;
    bit    done = 1'b0;
    string cur_req = "R12";

    always #5 clk = ~clk;

    serial_cmd_rx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_i    (sel_n),
        .fsync_i    (fs),
        .sclk_i     (sck),
        .sdata_i    (dat),
        .word_o     (word),
        .word_vld_o (vld)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [3:0]  hist[$];
    int          m_mode;   // 0 waiting, 1 collecting, 2 complete
    int          m_bits;
    logic [15:0] m_sh;
    logic [15:0] m_word;
    logic        m_vld;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist   = {4'b1110, 4'b1110, 4'b1110};
            m_mode = 0;
            m_bits = 0;
            m_sh   = '0;
            m_word = '0;
            m_vld  = 1'b0;
        end else begin
            logic [3:0] now_s;
            logic [3:0] was_s;
            now_s = hist[1];
            was_s = hist[2];
            m_vld = 1'b0;
            if (now_s[3]) begin
                m_mode = 0;
                m_bits = 0;
            end else if (was_s[2] && !now_s[2]) begin
                m_mode = 1;
                m_bits = 0;
            end else if (m_mode == 1) begin
                if (was_s[1] && !now_s[1]) begin
                    m_sh = {m_sh[14:0], now_s[0]};
                    m_bits++;
                    if (m_bits == 16) m_mode = 2;
                end
            end else if (m_mode == 2) begin
                if ((!was_s[1] && now_s[1]) || (!was_s[2] && now_s[2])) begin
                    m_word = m_sh;
                    m_vld  = 1'b1;
                    m_mode = 0;
                end
            end
            hist.push_front({sel_n, fs, sck, dat});
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(vld == m_vld, cur_req, "strobe vs model", {15'd0, vld}, {15'd0, m_vld});
            chk(word == m_word, cur_req, "word vs model", word, m_word);
        end
        if (rst_n && vld) strobes++;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_frame();
        fs = 1'b1;
        wait_clk(HALF);
        fs = 1'b0;
        wait_clk(HALF);
    endtask

    // leaves the serial clock low after the last bit
    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            dat = w[15-i];
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
            if (i < n - 1) sck = 1'b1;
        end
    endtask

    task automatic rise_sck();
        sck = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic expect_result(input string req, input int n_before,
                                 input int n_delta, input logic [15:0] exp_w);
        wait_clk(6);
        chk(strobes == n_before + n_delta, req, "strobe count",
            16'(strobes - n_before), 16'(n_delta));
        chk(word == exp_w, req, "word", word, exp_w);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int n0;
        wait_clk(3);
        // R12: reset state
        chk(word == 16'h0000, "R12", "word in reset", word, 16'h0000);
        chk(vld == 1'b0, "R12", "strobe in reset", {15'd0, vld}, 16'h0000);
        rst_n = 1'b1;
        wait_clk(4);
        chk(word == 16'h0000, "R12", "word after reset", word, 16'h0000);

        // R5 + R3: four-wire, release on serial clock rise
        cur_req = "R5";
        n0 = strobes;
        sel_n = 1'b0;
        wait_clk(HALF);
        start_frame();
        shift_bits(16'hA5C3, 16);
        rise_sck();
        expect_result("R5", n0, 1, 16'hA5C3);

        // R3: bit order, first bit lands in the MSB
        cur_req = "R3";
        n0 = strobes;
        start_frame();
        shift_bits(16'h8001, 16);
        rise_sck();
        expect_result("R3", n0, 1, 16'h8001);

        // R6: release on frame sync rise before the serial clock rises
        cur_req = "R6";
        n0 = strobes;
        start_frame();
        shift_bits(16'h3C5A, 16);
        fs = 1'b1;
        wait_clk(HALF);
        rise_sck();
        expect_result("R6", n0, 1, 16'h3C5A);

        // R11: strobe timing after the releasing edge
        cur_req = "R11";
        start_frame();
        shift_bits(16'h1234, 16);
        sck = 1'b1;
        @(negedge clk);
        chk(vld == 1'b0, "R11", "strobe after 1 edge", {15'd0, vld}, 16'h0000);
        @(negedge clk);
        chk(vld == 1'b0, "R11", "strobe after 2 edges", {15'd0, vld}, 16'h0000);
        @(negedge clk);
        chk(vld == 1'b1, "R11", "strobe after 3 edges", {15'd0, vld}, 16'h0001);
        // R10: single cycle pulse
        @(negedge clk);
        chk(vld == 1'b0, "R10", "strobe one cycle", {15'd0, vld}, 16'h0000);
        chk(word == 16'h1234, "R10", "word after pulse", word, 16'h1234);

        // R9: serial clock after release changes nothing
        cur_req = "R9";
        n0 = strobes;
        shift_bits(16'hFFFF, 16);
        rise_sck();
        expect_result("R9", n0, 0, 16'h1234);

        // R4: fifteen bits are not a word
        cur_req = "R4";
        n0 = strobes;
        start_frame();
        shift_bits(16'h7777, 15);
        rise_sck();
        fs = 1'b1;
        wait_clk(HALF);
        expect_result("R4", n0, 0, 16'h1234);

        // R2: restart mid-frame drops earlier bits
        cur_req = "R2";
        n0 = strobes;
        start_frame();
        shift_bits(16'hFE00, 7);
        rise_sck();
        start_frame();
        shift_bits(16'h0F0F, 16);
        rise_sck();
        expect_result("R2", n0, 1, 16'h0F0F);

        // R8: deselect with a partial word, then a clean frame
        cur_req = "R8";
        n0 = strobes;
        start_frame();
        shift_bits(16'hDEAD, 10);
        sel_n = 1'b1;
        wait_clk(HALF);
        rise_sck();
        expect_result("R8", n0, 0, 16'h0F0F);
        sel_n = 1'b0;
        wait_clk(HALF);
        start_frame();
        shift_bits(16'hBEEF, 16);
        rise_sck();
        expect_result("R8", n0, 1, 16'hBEEF);

        // R1: a whole frame while deselected is ignored
        cur_req = "R1";
        n0 = strobes;
        sel_n = 1'b1;
        wait_clk(HALF);
        start_frame();
        shift_bits(16'h5555, 16);
        rise_sck();
        fs = 1'b1;
        wait_clk(HALF);
        expect_result("R1", n0, 0, 16'hBEEF);

        // R13: deselect and release in the same sample
        cur_req = "R13";
        n0 = strobes;
        sel_n = 1'b0;
        wait_clk(HALF);
        start_frame();
        shift_bits(16'hC0DE, 16);
        sck = 1'b1;
        sel_n = 1'b1;
        wait_clk(HALF);
        expect_result("R13", n0, 0, 16'hBEEF);

        // R7: three-wire, select held low, back-to-back words
        cur_req = "R7";
        n0 = strobes;
        sel_n = 1'b0;
        start_frame();
        shift_bits(16'h0001, 16);
        rise_sck();
        expect_result("R7", n0, 1, 16'h0001);
        start_frame();
        shift_bits(16'hFFFE, 16);
        rise_sck();
        expect_result("R7", n0, 2, 16'hFFFE);
        start_frame();
        shift_bits(16'h6A95, 16);
        fs = 1'b1;
        wait_clk(HALF);
        rise_sck();
        expect_result("R7", n0, 3, 16'h6A95);

        wait_clk(4);
        finish_run();
    end

endmodule